// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block steps a PLL through a fixed bring-up and teardown order. An enable request turns on the PLL bias and sets the system mux control to its active code. After a settle delay the block accepts divider values through a valid/ready handshake and starts the PLL. It then checks the lock status at a fixed interval. When lock is seen it opens the global output clock gate and, one step later, the resync buffer. If lock is not seen within the timeout, the sequence halts before the clock gate and reports failure.

A disable request tears the PLL down in the opposite order, so that no clock edge escapes while the analog parts lose power. The order is: clock gate off, PLL stop, resync buffer off, mux control cleared, bias off, then one more settle delay. A disable that arrives while lock polling is in progress abandons the polling and goes straight into teardown. When master mode is requested, a second (slave) PLL has its bias, mux control, clock gate and resync buffer driven in step with the master.

All delays are counted in reference clock cycles, derived from a clock-frequency parameter and from the nanosecond and microsecond figures. Every sequence ends with a one-cycle done pulse and a pass/fail flag.

Top module: `pll_pwr_seq`

## Requirements
- R1: When `en_req` is seen in idle, `bias_en` rises and `sys_mux` becomes 0xC0 on the next clock edge. `cfg_ready` rises SETTLE_CYC edges later, where SETTLE_CYC = ceil(CLK_KHZ*BIAS_NS/1e6), with a minimum of 1.
- R2: `cfg_ready` stays high while the block waits for dividers. On the edge that sees `cfg_valid` high, `cfg_dec`/`cfg_frac` are copied to `div_dec`/`div_frac`. `pll_start` rises on the edge after that.
- R3: Lock is sampled only on the edges that fall a whole multiple of POLL_CYC = CLK_KHZ*POLL_US/1000 after `pll_start` rises. Only bit 0 of `lock_stat` counts. A lock pulse that lies between sample edges, and any other bit, are ignored.
- R4: On the first sample edge that sees lock, `clk_gate_en` rises. On the next edge `rbuf_en` rises, `done` pulses with `pass`=1, and `busy` falls.
- R5: If all TIMEOUT_US/POLL_US samples miss lock, `done` pulses with `pass`=0 on the last sample edge. `clk_gate_en` and `rbuf_en` stay low, while `bias_en` and `pll_start` stay high until a disable.
- R6: For a `dis_req` seen on edge N in the on or failed state, the outputs change as follows:
  - `clk_gate_en` falls at N.
  - `pll_start` falls at N+1.
  - `rbuf_en` falls at N+2.
  - `sys_mux` clears to 0 at N+3.
  - `bias_en` falls at N+4.
  - `done` pulses with `pass`=1 at N+4+SETTLE_CYC.
- R7: A `dis_req` during lock polling starts the R6 teardown with the same timing, and `clk_gate_en` never rises, even if lock arrives later.
- R8: With `master_mode` high at the `en_req` edge, `slv_bias_en`, `slv_sys_mux`, `slv_clk_gate_en` and `slv_rbuf_en` equal the master's signals at all times until the next enable. With it low, they stay 0.
- R9: `busy` is high from the edge that accepts a request until the edge carrying `done`. `done` is a single-cycle pulse.
- R10: `en_req` is ignored outside idle. `dis_req` is ignored in idle.
- R11: Reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | Drive the slave PLL in step (sampled at enable) |
| en_req | input | 1 | Power-up request |
| dis_req | input | 1 | Power-down request |
| cfg_valid | input | 1 | Divider values are valid |
| cfg_dec | input | DEC_W | Integer divider value |
| cfg_frac | input | FRAC_W | Fractional divider value |
| cfg_ready | output | 1 | Block is waiting for divider values |
| lock_stat | input | STAT_W | PLL status; bit 0 is lock |
| div_dec | output | DEC_W | Captured integer divider |
| div_frac | output | FRAC_W | Captured fractional divider |
| bias_en | output | 1 | Master bias enable |
| sys_mux | output | MUX_W | Master system mux control |
| pll_start | output | 1 | Master PLL run |
| clk_gate_en | output | 1 | Master global clock gate enable |
| rbuf_en | output | 1 | Master resync buffer enable |
| slv_bias_en | output | 1 | Slave bias enable |
| slv_sys_mux | output | MUX_W | Slave system mux control |
| slv_clk_gate_en | output | 1 | Slave global clock gate enable |
| slv_rbuf_en | output | 1 | Slave resync buffer enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Result of the last sequence |

## Verification
The situations hardest to reach from the ports are three:
- a lock pulse that starts and ends between two sample edges;
- a status word with every bit set except bit 0;
- a disable that lands in the middle of polling.

The bench lock model therefore schedules lock relative to the measured `pll_start` rise, with an optional glitch window. A small clock parameter keeps the poll interval at a few hundred cycles, so the full timeout path and several lock delays can run to completion. Each expected edge is computed from the settle, poll and attempt counts.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    S_OFF,
    S_BIAS,
    S_PROG,
    S_START,
    S_POLL,
    S_RBUF,
    S_ON,
    S_FAULT,
    S_STOP,
    S_RBOFF,
    S_MUXOFF,
    S_BIASOFF,
    S_SETTLE
  } pps_state_e;

  function automatic int unsigned ceil_div(input longint unsigned num,
                                           input longint unsigned den);
    return int'((num + den - 1) / den);
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pps_attempt_ctr.sv
module pps_attempt_ctr #(
  parameter int N = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST_V = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_V);

endmodule

// File: rtl/pps_slave_mirror.sv
module pps_slave_mirror #(
  parameter bit HAS_SLAVE = 1'b1,
  parameter int MUX_W     = 8
) (
  input  logic             mode,
  input  logic             bias,
  input  logic [MUX_W-1:0] mux,
  input  logic             gate,
  input  logic             rbuf,
  output logic             slv_bias,
  output logic [MUX_W-1:0] slv_mux,
  output logic             slv_gate,
  output logic             slv_rbuf
);

  generate
    if (HAS_SLAVE) begin : g_slave
      assign slv_bias = bias & mode;
      assign slv_mux  = mux & {MUX_W{mode}};
      assign slv_gate = gate & mode;
      assign slv_rbuf = rbuf & mode;
    end else begin : g_none
      assign slv_bias = 1'b0;
      assign slv_mux  = '0;
      assign slv_gate = 1'b0;
      assign slv_rbuf = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 250000,
  parameter int unsigned BIAS_NS    = 250,
  parameter int unsigned POLL_US    = 100,
  parameter int unsigned TIMEOUT_US = 5000,
  parameter int          DEC_W      = 8,
  parameter int          FRAC_W     = 18,
  parameter int          STAT_W     = 8,
  parameter int          MUX_W      = 8,
  parameter logic [7:0]  MUX_ON     = 8'hC0,
  parameter bit          HAS_SLAVE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              cfg_valid,
  input  logic [DEC_W-1:0]  cfg_dec,
  input  logic [FRAC_W-1:0] cfg_frac,
  output logic              cfg_ready,
  input  logic [STAT_W-1:0] lock_stat,
  output logic [DEC_W-1:0]  div_dec,
  output logic [FRAC_W-1:0] div_frac,
  output logic              bias_en,
  output logic [MUX_W-1:0]  sys_mux,
  output logic              pll_start,
  output logic              clk_gate_en,
  output logic              rbuf_en,
  output logic              slv_bias_en,
  output logic [MUX_W-1:0]  slv_sys_mux,
  output logic              slv_clk_gate_en,
  output logic              slv_rbuf_en,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int unsigned SETTLE_CYC =
    at_least_one(ceil_div(longint'(CLK_KHZ) * BIAS_NS, 64'd1000000));
  localparam int unsigned POLL_CYC =
    at_least_one(int'((longint'(CLK_KHZ) * POLL_US) / 1000));
  localparam int unsigned MAX_POLLS = at_least_one(TIMEOUT_US / POLL_US);
  localparam int unsigned TMR_MAX =
    (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int TMR_W = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] POLL_LD   = TMR_W'(POLL_CYC - 1);
  localparam logic [MUX_W-1:0] MUX_ACT   = MUX_W'(MUX_ON);

  pps_state_e        state_q, state_d;
  logic              bias_q, bias_d;
  logic [MUX_W-1:0]  mux_q, mux_d;
  logic              start_q, start_d;
  logic              gate_q, gate_d;
  logic              rbuf_q, rbuf_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic              mode_q, mode_d;
  logic [DEC_W-1:0]  dec_q, dec_d;
  logic [FRAC_W-1:0] frac_q, frac_d;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              att_clr;
  logic              att_inc;
  logic              att_last;
  logic              lock_seen;

  assign lock_seen = lock_stat[0];

  pps_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  pps_attempt_ctr #(.N(int'(MAX_POLLS))) u_attempts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (att_clr),
    .inc   (att_inc),
    .last  (att_last)
  );

  // Next-state process
  always_comb begin
    state_d  = state_q;
    bias_d   = bias_q;
    mux_d    = mux_q;
    start_d  = start_q;
    gate_d   = gate_q;
    rbuf_d   = rbuf_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    pass_d   = pass_q;
    mode_d   = mode_q;
    dec_d    = dec_q;
    frac_d   = frac_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    att_clr  = 1'b0;
    att_inc  = 1'b0;

    unique case (state_q)
      S_OFF: begin
        if (en_req) begin
          bias_d   = 1'b1;
          mux_d    = MUX_ACT;
          busy_d   = 1'b1;
          mode_d   = master_mode;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
          state_d  = S_BIAS;
        end
      end
      S_BIAS: begin
        if (tmr_zero) state_d = S_PROG;
      end
      S_PROG: begin
        if (cfg_valid) begin
          dec_d   = cfg_dec;
          frac_d  = cfg_frac;
          state_d = S_START;
        end
      end
      S_START: begin
        start_d  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = POLL_LD;
        att_clr  = 1'b1;
        state_d  = S_POLL;
      end
      S_POLL: begin
        if (dis_req) begin
          gate_d  = 1'b0;
          busy_d  = 1'b1;
          state_d = S_STOP;
        end else if (tmr_zero) begin
          if (lock_seen) begin
            gate_d  = 1'b1;
            state_d = S_RBUF;
          end else if (att_last) begin
            done_d  = 1'b1;
            pass_d  = 1'b0;
            busy_d  = 1'b0;
            state_d = S_FAULT;
          end else begin
            att_inc  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = POLL_LD;
          end
        end
      end
      S_RBUF: begin
        rbuf_d  = 1'b1;
        done_d  = 1'b1;
        pass_d  = 1'b1;
        busy_d  = 1'b0;
        state_d = S_ON;
      end
      S_ON, S_FAULT: begin
        if (dis_req) begin
          gate_d  = 1'b0;
          busy_d  = 1'b1;
          state_d = S_STOP;
        end
      end
      S_STOP: begin
        start_d = 1'b0;
        state_d = S_RBOFF;
      end
      S_RBOFF: begin
        rbuf_d  = 1'b0;
        state_d = S_MUXOFF;
      end
      S_MUXOFF: begin
        mux_d   = '0;
        state_d = S_BIASOFF;
      end
      S_BIASOFF: begin
        bias_d   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
        state_d  = S_SETTLE;
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          done_d  = 1'b1;
          pass_d  = 1'b1;
          busy_d  = 1'b0;
          state_d = S_OFF;
        end
      end
      default: state_d = S_OFF;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      bias_q  <= 1'b0;
      mux_q   <= '0;
      start_q <= 1'b0;
      gate_q  <= 1'b0;
      rbuf_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      mode_q  <= 1'b0;
      dec_q   <= '0;
      frac_q  <= '0;
    end else begin
      state_q <= state_d;
      bias_q  <= bias_d;
      mux_q   <= mux_d;
      start_q <= start_d;
      gate_q  <= gate_d;
      rbuf_q  <= rbuf_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      mode_q  <= mode_d;
      dec_q   <= dec_d;
      frac_q  <= frac_d;
    end
  end

  pps_slave_mirror #(.HAS_SLAVE(HAS_SLAVE), .MUX_W(MUX_W)) u_mirror (
    .mode     (mode_q),
    .bias     (bias_q),
    .mux      (mux_q),
    .gate     (gate_q),
    .rbuf     (rbuf_q),
    .slv_bias (slv_bias_en),
    .slv_mux  (slv_sys_mux),
    .slv_gate (slv_clk_gate_en),
    .slv_rbuf (slv_rbuf_en)
  );

  assign cfg_ready   = (state_q == S_PROG);
  assign div_dec     = dec_q;
  assign div_frac    = frac_q;
  assign bias_en     = bias_q;
  assign sys_mux     = mux_q;
  assign pll_start   = start_q;
  assign clk_gate_en = gate_q;
  assign rbuf_en     = rbuf_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign pass        = pass_q;

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int MUX_W  = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] lock_stat,
  input logic              bias_en,
  input logic [MUX_W-1:0]  sys_mux,
  input logic              pll_start,
  input logic              clk_gate_en,
  input logic              rbuf_en,
  input logic              busy,
  input logic              done
);

  // R1: bias comes up with the mux control already active
  a_r1_mux_with_bias: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> (sys_mux != '0) && busy);

  // R2: the PLL is only started with bias already on
  a_r2_start_after_bias: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_start) |-> bias_en && $past(bias_en));

  // R4: the clock gate only opens on a sampled lock
  a_r4_gate_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> $past(lock_stat[0]) && pll_start);

  // R4: the resync buffer follows an open gate and ends the sequence
  a_r4_rbuf_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbuf_en) |-> clk_gate_en && $past(clk_gate_en) && done);

  // R6: the PLL stops only after the gate was closed
  a_r6_gate_before_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_start) |-> !clk_gate_en && !$past(clk_gate_en));

  // R6: bias drops last, with the mux already cleared
  a_r6_bias_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_en) |-> (sys_mux == '0) && !pll_start && !rbuf_en && !clk_gate_en);

  // R9: done is a single pulse and ends busy
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(.MUX_W(MUX_W), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_stat   (lock_stat),
  .bias_en     (bias_en),
  .sys_mux     (sys_mux),
  .pll_start   (pll_start),
  .clk_gate_en (clk_gate_en),
  .rbuf_en     (rbuf_en),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_pll_pwr_seq.sv
`timescale 1ns/1ps
module tb_pll_pwr_seq;

  localparam int CLK_KHZ = 8000;
  localparam int SETTLE  = (CLK_KHZ * 250 + 999999) / 1000000;
  localparam int POLL    = CLK_KHZ * 100 / 1000;
  localparam int NPOLL   = 5000 / 100;

  logic        clk;
  logic        rst_n;
  logic        master_mode;
  logic        en_req;
  logic        dis_req;
  logic        cfg_valid;
  logic [7:0]  cfg_dec;
  logic [17:0] cfg_frac;
  logic        cfg_ready;
  logic [7:0]  lock_stat;
  logic [7:0]  div_dec;
  logic [17:0] div_frac;
  logic        bias_en;
  logic [7:0]  sys_mux;
  logic        pll_start;
  logic        clk_gate_en;
  logic        rbuf_en;
  logic        slv_bias_en;
  logic [7:0]  slv_sys_mux;
  logic        slv_clk_gate_en;
  logic        slv_rbuf_en;
  logic        busy;
  logic        done;
  logic        pass;

  pll_pwr_seq #(.CLK_KHZ(CLK_KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .en_req(en_req),
    .dis_req(dis_req), .cfg_valid(cfg_valid), .cfg_dec(cfg_dec),
    .cfg_frac(cfg_frac), .cfg_ready(cfg_ready), .lock_stat(lock_stat),
    .div_dec(div_dec), .div_frac(div_frac), .bias_en(bias_en),
    .sys_mux(sys_mux), .pll_start(pll_start), .clk_gate_en(clk_gate_en),
    .rbuf_en(rbuf_en), .slv_bias_en(slv_bias_en), .slv_sys_mux(slv_sys_mux),
    .slv_clk_gate_en(slv_clk_gate_en), .slv_rbuf_en(slv_rbuf_en),
    .busy(busy), .done(done), .pass(pass)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // lock model settings (written by the stimulus only)
  int         lk_at  = 1 << 30;
  int         lk_glo = 0;
  int         lk_ghi = 0;
  logic [7:0] lk_hi  = 8'h01;
  logic       mode_exp = 1'b0;

  // monitor state (written by the monitor only)
  int t_bias_on = -1, t_ready_on = -1, t_start_on = -1, t_clk_on = -1;
  int t_rbuf_on = -1, t_done = -1, t_clk_off = -1, t_start_off = -1;
  int t_rbuf_off = -1, t_mux_off = -1, t_bias_off = -1;
  int done_cnt = 0, slv_bad = 0, busy_bad = 0;
  logic done_pass = 1'b0;
  logic [7:0] mux_at_bias = 8'h00;
  logic p_bias = 0, p_ready = 0, p_start = 0, p_clk = 0, p_rbuf = 0;
  logic [7:0] p_mux = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bias_en && !p_bias) begin t_bias_on = cyc; mux_at_bias = sys_mux; end
      if (!bias_en && p_bias) t_bias_off = cyc;
      if (cfg_ready && !p_ready) t_ready_on = cyc;
      if (pll_start && !p_start) t_start_on = cyc;
      if (!pll_start && p_start) t_start_off = cyc;
      if (clk_gate_en && !p_clk) t_clk_on = cyc;
      if (!clk_gate_en && p_clk) t_clk_off = cyc;
      if (rbuf_en && !p_rbuf) t_rbuf_on = cyc;
      if (!rbuf_en && p_rbuf) t_rbuf_off = cyc;
      if (sys_mux == 8'h00 && p_mux != 8'h00) t_mux_off = cyc;
      if (done) begin
        t_done = cyc; done_pass = pass; done_cnt++;
        if (busy) busy_bad++;
      end
      if (slv_bias_en != (bias_en & mode_exp) ||
          slv_sys_mux != (sys_mux & {8{mode_exp}}) ||
          slv_clk_gate_en != (clk_gate_en & mode_exp) ||
          slv_rbuf_en != (rbuf_en & mode_exp)) slv_bad++;
    end
    p_bias = bias_en; p_ready = cfg_ready; p_start = pll_start;
    p_clk = clk_gate_en; p_rbuf = rbuf_en; p_mux = sys_mux;
    if (pll_start && t_start_on >= 0 &&
        (((cyc - t_start_on) >= lk_glo && (cyc - t_start_on) < lk_ghi) ||
         (cyc - t_start_on) >= lk_at))
      lock_stat = lk_hi;
    else
      lock_stat = 8'h00;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done(input int c0);
    int n = 0;
    while (done_cnt == c0 && n < 60000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic pulse_en(output int t_req);
    @(negedge clk); en_req = 1'b1; t_req = cyc;
    @(negedge clk); en_req = 1'b0;
  endtask

  task automatic pulse_dis(output int t_req);
    @(negedge clk); dis_req = 1'b1; t_req = cyc;
    @(negedge clk); dis_req = 1'b0;
  endtask

  // power-up with immediate dividers and lock after d cycles
  task automatic run_up(input logic mode, input int d, input int glo, input int ghi);
    int t_req, c0;
    master_mode = mode; mode_exp = mode;
    lk_at = d; lk_glo = glo; lk_ghi = ghi; lk_hi = 8'h01;
    cfg_valid = 1'b1; cfg_dec = 8'h5A ^ 8'(d); cfg_frac = 18'h2A5A5 ^ 18'(d);
    c0 = done_cnt;
    pulse_en(t_req);
    chk("R9 busy after enable", busy, 1);
    wait_done(c0);
    chk("R1 bias edge", t_bias_on, t_req + 1);
    chk("R1 mux code at bias", mux_at_bias, 8'hC0);
    chk("R1 settle to ready", t_ready_on - t_bias_on, SETTLE);
    chk("R2 start edge", t_start_on, t_ready_on + 2);
    chk("R2 dec captured", div_dec, cfg_dec);
    chk("R3 gate on sample edge", t_clk_on, t_start_on + POLL * (d / POLL + 1));
    chk("R4 rbuf after gate", t_rbuf_on, t_clk_on + 1);
    chk("R4 done edge", t_done, t_clk_on + 1);
    chk("R4 pass", done_pass, 1);
    chk("R9 busy low at end", busy, 0);
  endtask

  task automatic run_down(input logic gate_was_on);
    int t_req, c0;
    c0 = done_cnt;
    pulse_dis(t_req);
    wait_done(c0);
    if (gate_was_on) chk("R6 gate off", t_clk_off, t_req + 1);
    chk("R6 start off", t_start_off, t_req + 2);
    chk("R6 mux cleared", t_mux_off, t_req + 4);
    chk("R6 bias off", t_bias_off, t_req + 5);
    chk("R6 done after settle", t_done, t_req + 5 + SETTLE);
    chk("R6 pass", done_pass, 1);
    chk("R6 all off", {bias_en, pll_start, clk_gate_en, rbuf_en, busy}, 0);
  endtask

  initial begin
    #760000;
    $display("FAIL watchdog expired (R9) actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int t_req, c0, ts;
    rst_n = 1'b0; master_mode = 1'b0; en_req = 1'b0; dis_req = 1'b0;
    cfg_valid = 1'b0; cfg_dec = '0; cfg_frac = '0;
    repeat (4) @(negedge clk);
    chk("R11 reset outputs",
        {bias_en, sys_mux, pll_start, clk_gate_en, rbuf_en, slv_bias_en,
         slv_sys_mux, slv_clk_gate_en, slv_rbuf_en, busy, done, pass, cfg_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: disable in idle does nothing
    c0 = done_cnt;
    pulse_dis(t_req);
    repeat (10) @(negedge clk);
    chk("R10 idle disable ignored", {bias_en, busy}, 0);
    chk("R10 idle disable no done", done_cnt, c0);

    // R2: held handshake, lock on first sample
    cfg_valid = 1'b0; master_mode = 1'b0; mode_exp = 1'b0;
    lk_at = 1; lk_glo = 0; lk_ghi = 0; lk_hi = 8'h01;
    c0 = done_cnt;
    pulse_en(t_req);
    repeat (SETTLE + 12) @(negedge clk);
    chk("R2 ready while waiting", cfg_ready, 1);
    chk("R2 no start before valid", pll_start, 0);
    cfg_dec = 8'h3C; cfg_frac = 18'h1F00D; cfg_valid = 1'b1; ts = cyc;
    wait_done(c0);
    chk("R2 start after valid", t_start_on, ts + 2);
    chk("R2 frac captured", div_frac, 18'h1F00D);
    chk("R2 dec captured", div_dec, 8'h3C);
    chk("R3 first sample lock", t_clk_on, t_start_on + POLL);
    chk("R4 pass", done_pass, 1);

    // R10: enable while on is ignored
    c0 = done_cnt;
    pulse_en(t_req);
    repeat (20) @(negedge clk);
    chk("R10 enable in on ignored", done_cnt, c0);
    chk("R10 still on", {busy, rbuf_en, clk_gate_en}, 3'b011);
    run_down(1'b1);

    // R8: master mode mirrors the slave
    run_up(1'b1, 1700, 0, 0);
    chk("R8 slave up", {slv_bias_en, slv_clk_gate_en, slv_rbuf_en}, 3'b111);
    run_down(1'b1);
    chk("R8 slave mirrored throughout", slv_bad, 0);

    // R3: glitch between samples ignored
    run_up(1'b0, 2500, 1000, 1100);
    run_down(1'b1);
    run_up(1'b1, 15900, 0, 0);
    run_down(1'b1);
    chk("R8 slave mirrored throughout", slv_bad, 0);

    // R5: timeout, status with only bit 0 clear
    master_mode = 1'b0; mode_exp = 1'b0;
    lk_at = 1; lk_glo = 0; lk_ghi = 0; lk_hi = 8'hFE;
    c0 = done_cnt;
    pulse_en(t_req);
    wait_done(c0);
    chk("R5 fail at last sample", t_done, t_start_on + POLL * NPOLL);
    chk("R5 pass low", done_pass, 0);
    chk("R3 upper bits ignored gate", clk_gate_en, 0);
    chk("R5 held on", {bias_en, pll_start, rbuf_en, busy}, 4'b1100);
    chk("R5 gate never opened", t_clk_on < t_req, 1);
    run_down(1'b0);

    // R7: disable during polling
    mode_exp = 1'b0; master_mode = 1'b0;
    lk_at = 5000; lk_hi = 8'h01; cfg_valid = 1'b1;
    c0 = done_cnt;
    pulse_en(t_req);
    while (!(pll_start && t_start_on > t_req)) @(negedge clk);
    while (cyc < t_start_on + 2000) @(negedge clk);
    ts = cyc;
    dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0;
    wait_done(c0);
    chk("R7 start off", t_start_off, ts + 2);
    chk("R7 bias off", t_bias_off, ts + 5);
    chk("R7 done", t_done, ts + 5 + SETTLE);
    repeat (6000) @(negedge clk);
    chk("R7 gate never opened", t_clk_on < t_req, 1);
    chk("R7 stays off", {bias_en, pll_start, clk_gate_en, busy}, 0);
    chk("R9 done never with busy", busy_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule